// File: doc/BRIEF.md
# Serial Management Slave with Interrupt Pair

This block is the management end of a two-wire serial bus as used by Ethernet physical-layer devices. It runs on the management clock, samples the data line on each rising clock edge, and recognises a frame only after at least 32 ones followed by a `0` and then a `1`. The header carries a 2-bit operation code, a 5-bit station address and a 5-bit register index. When the operation is valid and the station address matches the local strap, a write stores the 16-bit payload, and a read sends a turnaround and the 16-bit register value back through an output with a separate enable.

The register space is a flat file of general read/write words. One word is the interrupt mask and another collects interrupt events. Event inputs set bits in the collector word, and the interrupt output is high while any collected bit is also unmasked. A read of the collector word clears the bits it reported once the read finishes, and events that arrive during the read stay set. The strap supplies only the low three address bits; the upper two are always zero. Because a strap value of zero never answers, the block responds to addresses 1 to 7.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: A frame is accepted only after at least PRE_LEN (32) consecutive ones, a `0`, then a `1`. A shorter run of ones or any other start pair returns the parser to hunting, and no register changes.
- R2: Operation code `10` (first bit sent first) is a read and `01` is a write. The codes `00` and `11` cause no register change and no drive of the line.
- R3: The block responds only when the received 5-bit address equals {2'b00, strap} and the strap is non-zero. Any other address causes no drive and no register change.
- R4: In a read, the output enable stays low for the first turnaround bit, drives `0` for the second, and then drives 16 data bits most significant first. Every driven value changes after a falling clock edge.
- R5: In a write, the two turnaround bits are consumed and the next 16 bits, most significant first, are stored in the addressed register.
- R6: The output enable is low in every bit except the second turnaround bit and the data bits of an accepted read. It is low again in the bit that follows the last data bit.
- R7: Addresses 0 to NUM_REGS-1 (0 to 30) are storage. Address 31 reads as zero and ignores writes.
- R8: Register IEN_ADDR (22) is the read/write interrupt mask. Register IST_ADDR (23) collects events: an event input bit high at a rising edge sets the matching bit, and writes to it are ignored.
- R9: irq_o is high exactly when the collector AND the mask is non-zero.
- R10: A read of the collector clears the bits it returned at the rising edge that samples the last data bit. An event bit arriving in the same read, including on that final edge, stays set.
- R11: After reset the output enable and irq_o are low and every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| phy_strap | input | STRAP_W | Low bits of the local station address |
| mdio_i | input | 1 | Sampled state of the data line |
| mdio_o | output | 1 | Value driven onto the data line |
| mdio_oe | output | 1 | Output enable for the data line |
| irq_event | input | 16 | Interrupt event bits, one per collector bit |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The bench uses the default parameters: a 32-one preamble, 31 storage words and the mask/collector pair at 22 and 23. These make address 31 fall just past the end of the file, and they put the collector clear directly next to an ordinary read/write word. The strap input is three bits wide and is changed at run time between 5 and 0. This allows a mismatch to be sent with only the upper address bits set, and it allows the check that a zero strap never answers. Event pulses are placed at chosen bit positions inside a read of the collector, including the final data bit, so the clear and the new event land on the same edge.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int DATA_W   = 16;
  localparam int ADDR_W   = 5;
  localparam int HDR_BITS = 12;
  localparam int CNT_W    = 4;

  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;

  typedef logic [DATA_W-1:0] word_t;

  typedef enum logic [2:0] {
    PS_HUNT, PS_START, PS_HDR, PS_RTA, PS_RDATA, PS_WTA, PS_WDATA
  } mdio_state_e;

  function automatic logic [1:0] hdr_op(input logic [HDR_BITS-1:0] h);
    return h[11:10];
  endfunction

  function automatic logic [ADDR_W-1:0] hdr_phy(input logic [HDR_BITS-1:0] h);
    return h[9:5];
  endfunction

  function automatic logic [ADDR_W-1:0] hdr_reg(input logic [HDR_BITS-1:0] h);
    return h[4:0];
  endfunction

  // Zero strap never answers
  function automatic logic phy_match(input logic [ADDR_W-1:0] rx,
                                     input logic [ADDR_W-1:0] own);
    return (own != '0) && (rx == own);
  endfunction

  function automatic logic irq_level(input word_t st, input word_t en);
    return |(st & en);
  endfunction

  // Clear reported bits, then merge new events so none is lost
  function automatic word_t status_update(input word_t st, input word_t clr,
                                          input word_t ev);
    return (st & ~clr) | ev;
  endfunction

  // Data bit sent in a given read slot, MSB first
  function automatic logic tx_bit(input word_t w, input logic [CNT_W-1:0] idx);
    return w[(DATA_W-1) - int'(idx)];
  endfunction

  function automatic logic drive_slot(input mdio_state_e st,
                                      input logic [CNT_W-1:0] idx);
    return (st == PS_RDATA) || (st == PS_RTA && idx == CNT_W'(1));
  endfunction
endpackage

// File: rtl/mdio_frame_parser.sv
module mdio_frame_parser
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int STRAP_W = 3
) (
  input  logic               mdc,
  input  logic               rst_n,
  input  logic               mdio_i,
  input  logic [STRAP_W-1:0] phy_strap,
  output mdio_state_e        state_o,
  output logic [CNT_W-1:0]   bit_idx_o,
  output logic               rd_req_o,
  output logic               rd_done_o,
  output logic               wr_en_o,
  output logic [ADDR_W-1:0]  req_addr_o,
  output logic [ADDR_W-1:0]  reg_addr_o,
  output logic [ADDR_W-1:0]  phy_rx_o,
  output logic [ADDR_W-1:0]  own_addr_o,
  output word_t              wr_data_o
);
  localparam int PRE_W = $clog2(PRE_LEN + 1);

  mdio_state_e          state_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [PRE_W-1:0]     pre_q;
  logic [HDR_BITS-2:0]  hdr_q;
  logic [DATA_W-2:0]    wdat_q;
  logic [ADDR_W-1:0]    reg_q;
  logic [ADDR_W-1:0]    phy_q;

  logic [HDR_BITS-1:0]  hdr_full;
  logic                 hdr_last;
  logic                 hit;
  logic                 go_rd;
  logic                 go_wr;
  logic                 data_last;
  logic                 pre_full;
  logic [ADDR_W-1:0]    own_addr;

  assign own_addr  = ADDR_W'(phy_strap);
  assign hdr_full  = {hdr_q, mdio_i};
  assign hdr_last  = (state_q == PS_HDR) && (cnt_q == CNT_W'(HDR_BITS - 1));
  assign hit       = phy_match(hdr_phy(hdr_full), own_addr);
  assign go_rd     = hdr_last && hit && (hdr_op(hdr_full) == OP_READ);
  assign go_wr     = hdr_last && hit && (hdr_op(hdr_full) == OP_WRITE);
  assign data_last = (cnt_q == CNT_W'(DATA_W - 1));
  assign pre_full  = (pre_q == PRE_W'(PRE_LEN));

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_HUNT;
      cnt_q   <= '0;
      pre_q   <= '0;
      hdr_q   <= '0;
      wdat_q  <= '0;
      reg_q   <= '0;
      phy_q   <= '0;
    end else begin
      case (state_q)
        PS_HUNT: begin
          if (mdio_i) begin
            if (!pre_full) pre_q <= pre_q + PRE_W'(1);
          end else if (pre_full) begin
            state_q <= PS_START;
          end else begin
            pre_q <= '0;
          end
        end
        PS_START: begin
          pre_q <= '0;
          cnt_q <= '0;
          state_q <= mdio_i ? PS_HDR : PS_HUNT;
        end
        PS_HDR: begin
          hdr_q <= hdr_full[HDR_BITS-2:0];
          cnt_q <= cnt_q + CNT_W'(1);
          if (hdr_last) begin
            cnt_q   <= '0;
            reg_q   <= hdr_reg(hdr_full);
            phy_q   <= hdr_phy(hdr_full);
            state_q <= go_rd ? PS_RTA : (go_wr ? PS_WTA : PS_HUNT);
          end
        end
        PS_RTA, PS_WTA: begin
          cnt_q <= cnt_q + CNT_W'(1);
          if (cnt_q == CNT_W'(1)) begin
            cnt_q   <= '0;
            state_q <= (state_q == PS_RTA) ? PS_RDATA : PS_WDATA;
          end
        end
        PS_RDATA: begin
          cnt_q <= cnt_q + CNT_W'(1);
          if (data_last) begin
            cnt_q   <= '0;
            state_q <= PS_HUNT;
          end
        end
        PS_WDATA: begin
          wdat_q <= {wdat_q[DATA_W-3:0], mdio_i};
          cnt_q  <= cnt_q + CNT_W'(1);
          if (data_last) begin
            cnt_q   <= '0;
            state_q <= PS_HUNT;
          end
        end
        default: state_q <= PS_HUNT;
      endcase
    end
  end

  assign state_o    = state_q;
  assign bit_idx_o  = cnt_q;
  assign rd_req_o   = go_rd;
  assign rd_done_o  = (state_q == PS_RDATA) && data_last;
  assign wr_en_o    = (state_q == PS_WDATA) && data_last;
  assign wr_data_o  = {wdat_q, mdio_i};
  assign req_addr_o = hdr_reg(hdr_full);
  assign reg_addr_o = reg_q;
  assign phy_rx_o   = phy_q;
  assign own_addr_o = own_addr;
endmodule

// File: rtl/mdio_reg_file.sv
module mdio_reg_file
  import mdio_pkg::*;
#(
  parameter int NUM_REGS = 31,
  parameter int IEN_ADDR = 22,
  parameter int IST_ADDR = 23
) (
  input  logic              mdc,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  word_t             wr_data_i,
  input  logic              rd_req_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              rd_done_i,
  input  logic [ADDR_W-1:0] done_addr_i,
  input  word_t             ev_i,
  output word_t             rd_data_o,
  output word_t             ist_o,
  output word_t             ien_o,
  output logic              clr_o,
  output logic              irq_o
);
  word_t regs_w [NUM_REGS];
  word_t snap_q;
  word_t clr_mask;

  assign clr_o    = rd_done_i && (done_addr_i == ADDR_W'(IST_ADDR));
  assign clr_mask = clr_o ? snap_q : '0;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    word_t q_r;
    if (g == IST_ADDR) begin : g_ist
      always_ff @(posedge mdc or negedge rst_n) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= status_update(q_r, clr_mask, ev_i);
      end
    end else begin : g_rw
      always_ff @(posedge mdc or negedge rst_n) begin
        if (!rst_n)                                        q_r <= '0;
        else if (wr_en_i && (wr_addr_i == ADDR_W'(g)))      q_r <= wr_data_i;
      end
    end
    assign regs_w[g] = q_r;
  end

  always_comb begin
    rd_data_o = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (req_addr_i == ADDR_W'(k)) rd_data_o = regs_w[k];
    end
  end

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) snap_q <= '0;
    else if (rd_req_i && (req_addr_i == ADDR_W'(IST_ADDR))) snap_q <= regs_w[IST_ADDR];
  end

  assign ist_o = regs_w[IST_ADDR];
  assign ien_o = regs_w[IEN_ADDR];
  assign irq_o = irq_level(ist_o, ien_o);
endmodule

// File: rtl/mdio_tx_driver.sv
module mdio_tx_driver
  import mdio_pkg::*;
(
  input  logic             mdc,
  input  logic             rst_n,
  input  mdio_state_e      state_i,
  input  logic [CNT_W-1:0] bit_idx_i,
  input  logic             rd_req_i,
  input  word_t            rd_data_i,
  output logic             mdio_o,
  output logic             mdio_oe
);
  word_t shadow_q;

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n)        shadow_q <= '0;
    else if (rd_req_i) shadow_q <= rd_data_i;
  end

  // Launch on the falling edge: half a period of setup for the station
  always_ff @(negedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      mdio_oe <= 1'b0;
      mdio_o  <= 1'b0;
    end else begin
      mdio_oe <= drive_slot(state_i, bit_idx_i);
      mdio_o  <= (state_i == PS_RDATA) ? tx_bit(shadow_q, bit_idx_i) : 1'b0;
    end
  end
endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave
  import mdio_pkg::*;
#(
  parameter int PRE_LEN  = 32,
  parameter int NUM_REGS = 31,
  parameter int IEN_ADDR = 22,
  parameter int IST_ADDR = 23,
  parameter int STRAP_W  = 3
) (
  input  logic               mdc,
  input  logic               rst_n,
  input  logic [STRAP_W-1:0] phy_strap,
  input  logic               mdio_i,
  output logic               mdio_o,
  output logic               mdio_oe,
  input  logic [15:0]        irq_event,
  output logic               irq_o
);
  mdio_state_e       st_w;
  logic [CNT_W-1:0]  idx_w;
  logic              rd_req_w;
  logic              rd_done_w;
  logic              wr_en_w;
  logic [ADDR_W-1:0] req_addr_w;
  logic [ADDR_W-1:0] reg_addr_w;
  logic [ADDR_W-1:0] phy_rx_w;
  logic [ADDR_W-1:0] own_addr_w;
  word_t             wr_data_w;
  word_t             rd_data_w;
  word_t             ist_w;
  word_t             ien_w;
  logic              status_clr_w;

  mdio_frame_parser #(.PRE_LEN(PRE_LEN), .STRAP_W(STRAP_W)) u_parser (
    .mdc(mdc), .rst_n(rst_n), .mdio_i(mdio_i), .phy_strap(phy_strap),
    .state_o(st_w), .bit_idx_o(idx_w), .rd_req_o(rd_req_w),
    .rd_done_o(rd_done_w), .wr_en_o(wr_en_w), .req_addr_o(req_addr_w),
    .reg_addr_o(reg_addr_w), .phy_rx_o(phy_rx_w), .own_addr_o(own_addr_w),
    .wr_data_o(wr_data_w)
  );

  mdio_reg_file #(.NUM_REGS(NUM_REGS), .IEN_ADDR(IEN_ADDR), .IST_ADDR(IST_ADDR)) u_regs (
    .mdc(mdc), .rst_n(rst_n), .wr_en_i(wr_en_w), .wr_addr_i(reg_addr_w),
    .wr_data_i(wr_data_w), .rd_req_i(rd_req_w), .req_addr_i(req_addr_w),
    .rd_done_i(rd_done_w), .done_addr_i(reg_addr_w), .ev_i(irq_event),
    .rd_data_o(rd_data_w), .ist_o(ist_w), .ien_o(ien_w),
    .clr_o(status_clr_w), .irq_o(irq_o)
  );

  mdio_tx_driver u_tx (
    .mdc(mdc), .rst_n(rst_n), .state_i(st_w), .bit_idx_i(idx_w),
    .rd_req_i(rd_req_w), .rd_data_i(rd_data_w),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );
endmodule

// File: rtl/mdio_mgmt_checker.sv
module mdio_mgmt_checker
  import mdio_pkg::*;
(
  input logic              mdc,
  input logic              rst_n,
  input logic              mdio_o,
  input logic              mdio_oe,
  input logic              irq_o,
  input mdio_state_e       st,
  input logic [CNT_W-1:0]  bit_idx,
  input logic              wr_en,
  input logic              rd_done,
  input logic              status_clr,
  input logic [ADDR_W-1:0] phy_rx,
  input logic [ADDR_W-1:0] own_addr,
  input word_t             ist,
  input word_t             ien
);
  // R6: driver enable only inside the parser's read window
  p_oe_window_r6: assert property (@(posedge mdc) disable iff (!rst_n)
    mdio_oe |-> (st == PS_RDATA || (st == PS_RTA && bit_idx == CNT_W'(1))));

  // R4: second turnaround slot is driven low
  p_ta_low_r4: assert property (@(posedge mdc) disable iff (!rst_n)
    (st == PS_RTA && bit_idx == CNT_W'(1)) |-> (mdio_oe && !mdio_o));

  // R6: line released after the final data bit
  p_release_r6: assert property (@(posedge mdc) disable iff (!rst_n)
    rd_done |=> !mdio_oe);

  // R3: a store only follows a matching non-zero address
  p_wr_match_r3: assert property (@(posedge mdc) disable iff (!rst_n)
    wr_en |-> (phy_rx == own_addr && own_addr != '0));

  // R8: collector bits only fall on a clear pulse
  p_sticky_r8: assert property (@(posedge mdc) disable iff (!rst_n)
    !status_clr |=> ((ist & $past(ist)) == $past(ist)));

  // R9: no request while the mask is empty
  p_irq_mask_r9: assert property (@(posedge mdc) disable iff (!rst_n)
    (ien == '0) |-> !irq_o);
endmodule

bind mdio_mgmt_slave mdio_mgmt_checker chk_i (
  .mdc(mdc), .rst_n(rst_n), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .irq_o(irq_o),
  .st(st_w), .bit_idx(idx_w), .wr_en(wr_en_w), .rd_done(rd_done_w),
  .status_clr(status_clr_w), .phy_rx(phy_rx_w), .own_addr(own_addr_w),
  .ist(ist_w), .ien(ien_w)
);

// File: tb/mdio_mgmt_slave_tb.sv
module mdio_mgmt_slave_tb_top;
  localparam int CLK_PERIOD = 20;
  localparam int HALF = CLK_PERIOD / 2;
  localparam logic [18:0] RD_OE = 19'h3FFFE;

  logic        mdc = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  phy_strap = 3'd5;
  logic        mdio_in = 1'b1;
  logic [15:0] irq_event = '0;
  logic        mdio_o, mdio_oe, irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  mdio_mgmt_slave dut_i (
    .mdc(mdc), .rst_n(rst_n), .phy_strap(phy_strap), .mdio_i(mdio_in),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .irq_event(irq_event), .irq_o(irq_o)
  );

  always #HALF mdc = ~mdc;

  // {is_read, phy, reg, data, expect_response}
  localparam logic [27:0] VEC [16] = '{
    {1'b0, 5'd5,  5'd5,  16'hA5A5, 1'b0},
    {1'b1, 5'd5,  5'd5,  16'hA5A5, 1'b1},
    {1'b0, 5'd5,  5'd0,  16'h1234, 1'b0},
    {1'b1, 5'd5,  5'd0,  16'h1234, 1'b1},
    {1'b0, 5'd5,  5'd30, 16'h8001, 1'b0},
    {1'b1, 5'd5,  5'd30, 16'h8001, 1'b1},
    {1'b0, 5'd5,  5'd31, 16'hBEEF, 1'b0},
    {1'b1, 5'd5,  5'd31, 16'h0000, 1'b1},
    {1'b0, 5'd5,  5'd23, 16'hFFFF, 1'b0},
    {1'b1, 5'd5,  5'd23, 16'h0000, 1'b1},
    {1'b0, 5'd4,  5'd5,  16'h0000, 1'b0},
    {1'b1, 5'd5,  5'd5,  16'hA5A5, 1'b1},
    {1'b1, 5'd4,  5'd5,  16'h0000, 1'b0},
    {1'b1, 5'd13, 5'd5,  16'h0000, 1'b0},
    {1'b0, 5'd5,  5'd22, 16'h0000, 1'b0},
    {1'b1, 5'd5,  5'd22, 16'h0000, 1'b1}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One bit slot: drive after the falling edge, sample just before the rising edge
  task automatic send_bit(input logic b, input logic [15:0] ev,
                          output logic oe_s, output logic o_s);
    @(negedge mdc);
    #1;
    mdio_in = b;
    irq_event = ev;
    #(HALF - 3);
    oe_s = mdio_oe;
    o_s = mdio_o;
  endtask

  task automatic run_frame(input int pre, input logic [1:0] st, input logic [1:0] op,
                           input logic [4:0] phy, input logic [4:0] rg,
                           input logic [15:0] wd, input int ev_at,
                           input logic [15:0] ev_mask,
                           output logic [18:0] oe_b, output logic [18:0] o_b);
    logic so, sd;
    logic [11:0] hdr;
    send_bit(1'b0, '0, so, sd);
    for (int i = 0; i < pre; i++) send_bit(1'b1, '0, so, sd);
    send_bit(st[1], '0, so, sd);
    send_bit(st[0], '0, so, sd);
    hdr = {op, phy, rg};
    for (int i = 11; i >= 0; i--) send_bit(hdr[i], '0, so, sd);
    for (int i = 0; i < 19; i++) begin
      logic b;
      b = 1'b1;
      if (op == 2'b01 && i < 18) b = (i == 0) ? 1'b1 : (i == 1) ? 1'b0 : wd[17 - i];
      send_bit(b, (i == ev_at) ? ev_mask : 16'h0, oe_b[i], o_b[i]);
    end
  endtask

  task automatic do_write(input logic [4:0] phy, input logic [4:0] rg,
                          input logic [15:0] wd, output logic [18:0] oe_b);
    logic [18:0] o_b;
    run_frame(32, 2'b01, 2'b01, phy, rg, wd, -1, '0, oe_b, o_b);
  endtask

  task automatic do_read(input logic [4:0] phy, input logic [4:0] rg,
                         input int ev_at, input logic [15:0] ev_mask,
                         output logic [15:0] rd, output logic [18:0] oe_b,
                         output logic ta2);
    logic [18:0] o_b;
    run_frame(32, 2'b01, 2'b10, phy, rg, '0, ev_at, ev_mask, oe_b, o_b);
    for (int j = 0; j < 16; j++) rd[15 - j] = o_b[2 + j];
    ta2 = o_b[1];
  endtask

  task automatic pulse_ev(input logic [15:0] m);
    logic so, sd;
    send_bit(1'b1, m, so, sd);
    send_bit(1'b1, '0, so, sd);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] rd;
    logic [18:0] oe_b, o_b;
    logic ta2;

    repeat (3) @(negedge mdc);
    #(HALF - 3);
    chk("R11", "oe in reset", {31'b0, mdio_oe}, 0);
    chk("R11", "irq in reset", {31'b0, irq_o}, 0);
    @(negedge mdc);
    rst_n = 1'b1;

    do_read(5'd5, 5'd22, -1, '0, rd, oe_b, ta2);
    chk("R11", "mask after reset", {16'b0, rd}, 0);
    do_read(5'd5, 5'd7, -1, '0, rd, oe_b, ta2);
    chk("R11", "reg7 after reset", {16'b0, rd}, 0);

    // Vector table
    for (int v = 0; v < 16; v++) begin
      logic        is_rd, resp;
      logic [4:0]  phy, rg;
      logic [15:0] dat;
      string tag;
      {is_rd, phy, rg, dat, resp} = VEC[v];
      tag = (is_rd && !resp) ? "R3" : (rg == 5'd31) ? "R7" : (rg == 5'd23) ? "R8" : "R5";
      if (!is_rd) begin
        do_write(phy, rg, dat, oe_b);
        chk("R6", "no drive on write", {13'b0, oe_b}, 0);
      end else begin
        do_read(phy, rg, -1, '0, rd, oe_b, ta2);
        if (resp) begin
          chk("R4", "read oe pattern", {13'b0, oe_b}, {13'b0, RD_OE});
          chk("R4", "turnaround low", {31'b0, ta2}, 0);
          chk(tag, "read data", {16'b0, rd}, {16'b0, dat});
        end else begin
          chk(tag, "no response", {13'b0, oe_b}, 0);
        end
      end
    end

    // R1: short preamble and bad start are ignored
    run_frame(31, 2'b01, 2'b01, 5'd5, 5'd5, 16'h0000, -1, '0, oe_b, o_b);
    do_read(5'd5, 5'd5, -1, '0, rd, oe_b, ta2);
    chk("R1", "short preamble ignored", {16'b0, rd}, 32'hA5A5);
    run_frame(32, 2'b00, 2'b01, 5'd5, 5'd5, 16'h0000, -1, '0, oe_b, o_b);
    do_read(5'd5, 5'd5, -1, '0, rd, oe_b, ta2);
    chk("R1", "bad start ignored", {16'b0, rd}, 32'hA5A5);

    // R2: unused operation codes
    run_frame(32, 2'b01, 2'b11, 5'd5, 5'd5, 16'h0000, -1, '0, oe_b, o_b);
    do_read(5'd5, 5'd5, -1, '0, rd, oe_b, ta2);
    chk("R2", "op 11 no store", {16'b0, rd}, 32'hA5A5);
    run_frame(32, 2'b01, 2'b00, 5'd5, 5'd5, 16'h0000, -1, '0, oe_b, o_b);
    chk("R2", "op 00 no drive", {13'b0, oe_b}, 0);

    // R3: zero strap never answers
    phy_strap = 3'd0;
    do_read(5'd0, 5'd5, -1, '0, rd, oe_b, ta2);
    chk("R3", "strap zero silent", {13'b0, oe_b}, 0);
    phy_strap = 3'd5;

    // R8 R9 R10: interrupt pair
    do_write(5'd5, 5'd22, 16'h0004, oe_b);
    pulse_ev(16'h0001);
    chk("R9", "masked event no irq", {31'b0, irq_o}, 0);
    pulse_ev(16'h0004);
    chk("R9", "unmasked event irq", {31'b0, irq_o}, 1);
    do_read(5'd5, 5'd23, 17, 16'h0100, rd, oe_b, ta2);
    chk("R8", "collector value", {16'b0, rd}, 32'h0005);
    chk("R10", "irq cleared by read", {31'b0, irq_o}, 0);
    do_read(5'd5, 5'd23, 4, 16'h0200, rd, oe_b, ta2);
    chk("R10", "event on last edge kept", {16'b0, rd}, 32'h0100);
    do_read(5'd5, 5'd23, -1, '0, rd, oe_b, ta2);
    chk("R10", "event mid read kept", {16'b0, rd}, 32'h0200);
    do_read(5'd5, 5'd23, -1, '0, rd, oe_b, ta2);
    chk("R10", "collector empty", {16'b0, rd}, 0);

    finish_run();
  end
endmodule